// File: doc/BRIEF.md
# Flash rewrite control register

This block is the control and status register that a CPU uses to move its on-chip flash into and out of a software-driven rewrite mode. Software writes the register over a simple strobe-and-data bus and reads it back combinationally. One bit reports whether the flash engine is busy. One bit enables rewrite mode. One bit suppresses block-lock protection. One bit holds the flash controller in reset and removes its power.

The three writable control bits are guarded. A bit becomes 1 only when a register write carrying 0 in that position is followed, on the very next register write, by a write carrying 1. Setting the mode bit also needs a high NMI level. The lock override and the controller reset can only move while rewrite mode is on. The controller reset can only be released while the engine is idle. Clearing rewrite mode drops both dependent bits in the same cycle.

Flash power is also gated while the CPU sleeps, and this gating leaves the register contents alone. An erase request made while the lock override is active produces a pulse that tells the engine to turn locked lock data into unlocked.

Top module: `flash_rw_ctl`

## Requirements
- R1: Read bit 0 is 1 while `flash_busy_i` is low and 0 while it is high. Writes to bit 0 have no effect. Bits above 3 read 0.
- R2: Rewrite enable (bit 1) becomes 1 only on a write with bit 1 = 1 whose immediately preceding register write had bit 1 = 0. Any single write with bit 1 = 0 clears it.
- R3: A set of bit 1 is accepted only while the NMI level, after `NMI_SYNC` synchronizer stages, is high.
- R4: Lock override (bit 2) is set by the same 0-then-1 write pair and changes only while bit 1 is 1. Writes to bit 2 while bit 1 is 0 leave it 0.
- R5: Controller reset (bit 3) is set by a 0-then-1 write pair only while bit 1 is 1.
- R6: A write with bit 3 = 0 clears bit 3 only while `flash_busy_i` is low. While busy, the clear is ignored.
- R7: Any write that clears bit 1 forces bits 2 and 3 to 0 on the same clock edge, even while busy.
- R8: While bit 3 is 1, `flash_pwr_o` is 0 and `array_block_o` is 1.
- R9: While `cpu_sleep_i` is high, `flash_pwr_o` is 0 and `array_block_o` is 1. The register value read back is unchanged.
- R10: `unlock_o` is high exactly while `erase_req_i` is high and bit 2 is 1. Bit 2 itself is not altered by the erase.
- R11: A write with 1 in a guarded bit that does not immediately follow a write with 0 in that bit leaves the bit unchanged. This includes the case where the earlier write was refused.
- R12: After reset, all writable bits are 0 and no sequence is armed: a first write of 1 sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe, one cycle per write |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read value: {0, reset, override, mode, ready} |
| flash_busy_i | input | 1 | Flash engine is programming or erasing |
| nmi_i | input | 1 | NMI pin level |
| cpu_sleep_i | input | 1 | CPU is in stop or wait state |
| erase_req_i | input | 1 | Erase being performed by the engine |
| rewrite_en_o | output | 1 | Rewrite mode enabled |
| lock_ovr_o | output | 1 | Lock protection suppressed |
| ctl_reset_o | output | 1 | Flash controller held in reset |
| flash_pwr_o | output | 1 | Flash array power enable |
| array_block_o | output | 1 | Array accesses blocked |
| unlock_o | output | 1 | Erase should leave lock data unlocked |

## Verification
The bench builds the block with `DATA_W = 8` and `NMI_SYNC = 2`. The 8-bit width makes the zero upper read bits observable. The two-stage synchronizer means the NMI level must settle before a set is tried. This exercises a set refused for low NMI and then retried without a fresh arming write. The bench also covers refused clears of the controller reset while busy, and the forced drop of dependent bits during a busy cycle.

// File: rtl/flash_rw_ctl_pkg.sv
package flash_rw_ctl_pkg;
  // Bit positions decoded by software
  localparam int unsigned BIT_RDY  = 0;
  localparam int unsigned BIT_REWR = 1;
  localparam int unsigned BIT_LOVR = 2;
  localparam int unsigned BIT_CRST = 3;
  localparam int unsigned N_CTL    = 3;

  typedef struct packed {
    logic crst;
    logic lovr;
    logic rewr;
  } ctl_bits_t;
endpackage

// File: rtl/frw_sync.sv
module frw_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else if (STAGES == 1) chain_q <= d_i;
        else chain_q <= {chain_q[STAGES-2:0], d_i};
      end
      assign q_o = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/frw_arm_bit.sv
// Guarded bit: set needs a 0-write then a 1-write on consecutive writes.
module frw_arm_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic set_ok_i,
  input  logic clr_ok_i,
  input  logic force_clr_i,
  output logic q_o
);
  logic armed_q;
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else if (wr_i) armed_q <= ~wbit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else if (force_clr_i) q_q <= 1'b0;
    else if (wr_i && !wbit_i && clr_ok_i) q_q <= 1'b0;
    else if (wr_i && wbit_i && armed_q && set_ok_i) q_q <= 1'b1;
  end

  assign q_o = q_q;
endmodule

// File: rtl/frw_pwr.sv
module frw_pwr (
  input  logic ctl_reset_i,
  input  logic sleep_i,
  output logic pwr_o,
  output logic block_o
);
  always_comb begin
    pwr_o   = ~(ctl_reset_i | sleep_i);
    block_o = ctl_reset_i | sleep_i;
  end
endmodule

// File: rtl/flash_rw_ctl.sv
module flash_rw_ctl
  import flash_rw_ctl_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned NMI_SYNC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              flash_busy_i,
  input  logic              nmi_i,
  input  logic              cpu_sleep_i,
  input  logic              erase_req_i,
  output logic              rewrite_en_o,
  output logic              lock_ovr_o,
  output logic              ctl_reset_o,
  output logic              flash_pwr_o,
  output logic              array_block_o,
  output logic              unlock_o
);
  localparam int unsigned TOP_BIT = BIT_CRST;

  ctl_bits_t ctl;
  logic nmi_ok;
  logic ready;
  logic mode_drop;
  logic [N_CTL-1:0] set_ok, clr_ok, force_clr, wbit, q;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata_i;
  assign ready        = ~flash_busy_i;
  // Mode bit cleared by this write: dependents drop on the same edge
  assign mode_drop    = ~ctl.rewr | (reg_we_i & ~reg_wdata_i[BIT_REWR]);

  frw_sync #(.STAGES(NMI_SYNC)) u_nmi_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (nmi_i),
    .q_o   (nmi_ok)
  );

  always_comb begin
    set_ok    = {ctl.rewr, ctl.rewr, nmi_ok};
    clr_ok    = {ready,    ctl.rewr, 1'b1};
    force_clr = {mode_drop, mode_drop, 1'b0};
    wbit      = reg_wdata_i[TOP_BIT:BIT_REWR];
  end

  for (genvar i = 0; i < N_CTL; i++) begin : g_bit
    frw_arm_bit u_bit (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (reg_we_i),
      .wbit_i     (wbit[i]),
      .set_ok_i   (set_ok[i]),
      .clr_ok_i   (clr_ok[i]),
      .force_clr_i(force_clr[i]),
      .q_o        (q[i])
    );
  end

  assign ctl = ctl_bits_t'(q);

  frw_pwr u_pwr (
    .ctl_reset_i(ctl.crst),
    .sleep_i    (cpu_sleep_i),
    .pwr_o      (flash_pwr_o),
    .block_o    (array_block_o)
  );

  always_comb begin
    reg_rdata_o           = '0;
    reg_rdata_o[BIT_RDY]  = ready;
    reg_rdata_o[BIT_REWR] = ctl.rewr;
    reg_rdata_o[BIT_LOVR] = ctl.lovr;
    reg_rdata_o[BIT_CRST] = ctl.crst;
  end

  assign rewrite_en_o = ctl.rewr;
  assign lock_ovr_o   = ctl.lovr;
  assign ctl_reset_o  = ctl.crst;
  assign unlock_o     = erase_req_i & ctl.lovr;
endmodule

// File: rtl/flash_rw_ctl_chk.sv
module flash_rw_ctl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic reg_we_i,
  input logic wbit_rewr_i,
  input logic flash_busy_i,
  input logic nmi_ok_i,
  input logic cpu_sleep_i,
  input logic rewrite_en_o,
  input logic lock_ovr_o,
  input logic ctl_reset_o,
  input logic flash_pwr_o,
  input logic array_block_o
);
  AST_MODE_SET_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rewrite_en_o) |-> $past(reg_we_i && wbit_rewr_i)); // R2
  AST_MODE_SET_NMI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rewrite_en_o) |-> $past(nmi_ok_i)); // R3
  AST_LOVR_NEEDS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_ovr_o) |-> $past(rewrite_en_o)); // R4
  AST_CRST_NEEDS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctl_reset_o) |-> $past(rewrite_en_o)); // R5
  AST_CRST_CLR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ctl_reset_o) && rewrite_en_o) |-> $past(!flash_busy_i)); // R6
  AST_DEPS_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rewrite_en_o |-> (!lock_ovr_o && !ctl_reset_o)); // R7
  AST_CRST_PWR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_reset_o |-> (!flash_pwr_o && array_block_o)); // R8
  AST_SLEEP_PWR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_sleep_i |-> (!flash_pwr_o && array_block_o)); // R9
endmodule

bind flash_rw_ctl flash_rw_ctl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_we_i     (reg_we_i),
  .wbit_rewr_i  (reg_wdata_i[1]),
  .flash_busy_i (flash_busy_i),
  .nmi_ok_i     (nmi_ok),
  .cpu_sleep_i  (cpu_sleep_i),
  .rewrite_en_o (rewrite_en_o),
  .lock_ovr_o   (lock_ovr_o),
  .ctl_reset_o  (ctl_reset_o),
  .flash_pwr_o  (flash_pwr_o),
  .array_block_o(array_block_o)
);

// File: tb/tb_flash_rw_ctl.sv
module tb_flash_rw_ctl;
  localparam int unsigned DATA_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic reg_we = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic busy = 1'b0, nmi = 1'b1, sleep = 1'b0, erase = 1'b0;
  logic rew, lovr, crst, pwr, blk, unl;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    string       req;
    logic [13:0] exp;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  flash_rw_ctl #(.DATA_W(DATA_W), .NMI_SYNC(2)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .flash_busy_i(busy), .nmi_i(nmi),
    .cpu_sleep_i(sleep), .erase_req_i(erase), .rewrite_en_o(rew),
    .lock_ovr_o(lovr), .ctl_reset_o(crst), .flash_pwr_o(pwr),
    .array_block_o(blk), .unlock_o(unl)
  );

  // {unlock, block, pwr, crst, lovr, rew, rdata[7:0]}
  function automatic logic [13:0] model(logic e_rew, logic e_lovr, logic e_crst);
    logic [7:0] rd;
    rd = {4'b0000, e_crst, e_lovr, e_rew, ~busy};
    return {erase & e_lovr, e_crst | sleep, ~(e_crst | sleep), e_crst, e_lovr, e_rew, rd};
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [DATA_W-1:0] v);
    @(negedge clk);
    reg_we = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // Push expectation; monitor compares after the next rising edge
  task automatic expect_st(string req, logic e_rew, logic e_lovr, logic e_crst);
    item_t it;
    it.req = req;
    it.exp = model(e_rew, e_lovr, e_crst);
    sb.push_back(it);
    @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #5;
      while (sb.size() > 0) begin
        item_t it;
        logic [13:0] obs;
        it = sb.pop_front();
        obs = {unl, blk, pwr, crst, lovr, rew, reg_rdata};
        n_tests++;
        if (obs !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %b expected %b", it.req, obs, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : driver
    idle(3);
    rst_ni = 1'b1;
    idle(4);
    expect_st("R12 reset state", 0, 0, 0);
    wr(8'h02); expect_st("R12 no arm after reset", 0, 0, 0);
    wr(8'h00); wr(8'h02); expect_st("R2 set by 0 then 1", 1, 0, 0);
    wr(8'hF3); expect_st("R1 bit0 write ignored, upper zero", 1, 0, 0);
    busy = 1'b1; expect_st("R1 busy reads 0", 1, 0, 0);
    busy = 1'b0;
    wr(8'h00); expect_st("R2 single 0 clears", 0, 0, 0);
    nmi = 1'b0; idle(3);
    wr(8'h00); wr(8'h02); expect_st("R3 refused with nmi low", 0, 0, 0);
    nmi = 1'b1; idle(3);
    wr(8'h02); expect_st("R11 retry without arming", 0, 0, 0);
    wr(8'h00); wr(8'h02); expect_st("R3 accepted with nmi high", 1, 0, 0);
    wr(8'h06); expect_st("R4 override set", 1, 1, 0);
    wr(8'h06); expect_st("R11 repeated 1 holds", 1, 1, 0);
    erase = 1'b1; expect_st("R10 unlock with override", 1, 1, 0);
    wr(8'h02); expect_st("R10 R4 override cleared in mode", 1, 0, 0);
    expect_st("R10 no unlock without override", 1, 0, 0);
    erase = 1'b0;
    wr(8'h00); wr(8'h04); expect_st("R4 ignored outside mode", 0, 0, 0);
    wr(8'h00); wr(8'h08); expect_st("R5 refused outside mode", 0, 0, 0);
    wr(8'h00); wr(8'h02); wr(8'h0A); expect_st("R5 R8 reset set, power off", 1, 0, 1);
    busy = 1'b1;
    wr(8'h02); expect_st("R6 clear ignored while busy", 1, 0, 1);
    busy = 1'b0;
    wr(8'h02); expect_st("R6 clear when ready", 1, 0, 0);
    wr(8'h06); wr(8'h0E); expect_st("R7 setup all set", 1, 1, 1);
    busy = 1'b1;
    wr(8'h00); expect_st("R7 mode clear drops deps", 0, 0, 0);
    busy = 1'b0;
    wr(8'h00); wr(8'h02);
    sleep = 1'b1; expect_st("R9 sleep cuts power", 1, 0, 0);
    sleep = 1'b0; expect_st("R9 power back, reg kept", 1, 0, 0);
    idle(2);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule